// File: doc/BRIEF.md
# Critical-Word-First Burst Sequencer

This block sits on the memory-controller side of a 64-bit data bus. It
sequences one cache-block transfer at a time. A cache block is 32 bytes, moved
as four 8-byte double-word beats. A requester offers a burst with a byte
address and a direction flag. Once the sequencer takes a burst, it presents
four beats in turn. Each beat carries the double-word index within the block,
the full memory address of that double word, and a flag that marks the final
beat.

Read bursts are critical-word-first. The double word named by address bits
[4:3] goes out first. The remaining double words follow in rising order and
wrap back to double word zero of the same block. Write bursts must name the
start of the block, so they step 0, 1, 2, 3. The sequencer refuses a request
whose low three address bits are not zero. It also refuses a write whose bits
[4:3] are not zero. Either refusal raises a one-cycle error pulse and produces
no beats. Memory can hold any beat with a per-cycle ready input.

Top module: `cwf_burst_seq`

## Requirements
- R1: After reset, `beat_valid` and `req_err` are 0 and `req_ready` is 1.
- R2: A taken read burst presents exactly four beats. Beat k carries `beat_idx` = (`req_addr[4:3]` + k) mod 4, so a start of 1 gives 1,2,3,0 and a start of 3 gives 3,0,1,2.
- R3: `beat_addr` on every beat equals {`req_addr[31:5]`, `beat_idx`, 3'b000}. Bits [31:5] come from the request and bits [2:0] are zero.
- R4: `beat_last` is 1 on the fourth beat of a burst and 0 on the other three.
- R5: While `beat_valid` is 1 and `mem_ready` is 0, the beat is held: `beat_idx`, `beat_addr` and `beat_last` keep their values and no beat is used up.
- R6: A request with `req_addr[2:0]` not zero is refused. `req_err` is 1 for exactly the cycle after the request edge, and `beat_valid` stays 0.
- R7: A write request (`req_write` = 1) with `req_addr[4:3]` not zero is refused in the same way as R6. A write request with `req_addr[4:0]` = 0 runs beats 0,1,2,3.
- R8: `req_ready` is 0 while a burst is in progress. A request presented then is ignored and does not change the running beat sequence.
- R9: `req_ready` is 1 again in the cycle after the fourth beat is taken with `mem_ready` = 1, and `beat_valid` is then 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| req_valid | input | 1 | Burst request offered |
| req_write | input | 1 | 1 = write burst, 0 = read burst |
| req_addr | input | 32 | Byte address of the request |
| req_ready | output | 1 | Sequencer idle; a request is taken on this cycle's edge |
| req_err | output | 1 | One-cycle pulse: the last taken request was refused |
| mem_ready | input | 1 | Memory takes the current beat on this edge |
| beat_valid | output | 1 | A beat is being presented |
| beat_idx | output | 2 | Double-word index within the block for this beat |
| beat_addr | output | 32 | Memory byte address of this beat |
| beat_last | output | 1 | This beat is the fourth of the burst |

## Verification
The bench builds the block with its default parameters: a 32-bit address, four
beats per block and 8-byte beats. With these values every start position of
the wrap is reachable, as are the all-ones and all-zeros ends of the upper
address field. The table runs each read start through a full burst and
combines writes with both alignment faults. Directed sequences then hold a beat
with `mem_ready` low, present a competing request during a burst, and keep
`req_valid` high across back-to-back bursts to reach the turnaround cycle.

// File: rtl/cwf_pkg.sv
package cwf_pkg;

  typedef enum logic {
    SEQ_IDLE = 1'b0,
    SEQ_BUSY = 1'b1
  } seq_state_e;

endpackage

// File: rtl/cwf_align_chk.sv
// Decides whether an offered burst address is legal for its direction.
module cwf_align_chk #(
  parameter int ADDR_W = 32,
  parameter int IDX_W  = 2,
  parameter int OFS_W  = 3
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              write,
  output logic              bad
);

  localparam int BLK_W = IDX_W + OFS_W;

  logic lo_bad;
  logic wr_bad;

  always_comb begin
    lo_bad = |addr[OFS_W-1:0];
    wr_bad = write && (|addr[BLK_W-1:OFS_W]);
    bad    = lo_bad || wr_bad;
  end

endmodule

// File: rtl/cwf_beat_ctr.sv
// Counts beats within a burst and forms the wrapped double-word index.
module cwf_beat_ctr #(
  parameter int BEATS = 4,
  localparam int IDX_W = $clog2(BEATS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [IDX_W-1:0] start,
  input  logic             advance,
  output logic [IDX_W-1:0] idx,
  output logic             last
);

  logic [IDX_W-1:0] start_q;
  logic [IDX_W-1:0] start_d;
  logic             start_en;
  logic [IDX_W-1:0] cnt_q;
  logic [IDX_W-1:0] cnt_d;
  logic             cnt_en;

  always_comb begin
    start_en = load;
    start_d  = start;
    cnt_en   = load || advance;
    cnt_d    = load ? '0 : cnt_q + IDX_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      start_q <= '0;
      cnt_q   <= '0;
    end else begin
      if (start_en) start_q <= start_d;
      if (cnt_en)   cnt_q   <= cnt_d;
    end
  end

  // Power-of-two block: the sum truncates, which is the wrap.
  always_comb begin
    idx  = start_q + cnt_q;
    last = (cnt_q == IDX_W'(BEATS - 1));
  end

  // R2
  load_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (idx == $past(start)) && (cnt_q == '0));

endmodule

// File: rtl/cwf_addr_gen.sv
// Forms the beat byte address from the block base and the beat index.
module cwf_addr_gen #(
  parameter int ADDR_W = 32,
  parameter int IDX_W  = 2,
  parameter int OFS_W  = 3,
  localparam int BLK_W = IDX_W + OFS_W
) (
  input  logic [ADDR_W-BLK_W-1:0] base,
  input  logic [IDX_W-1:0]        idx,
  output logic [ADDR_W-1:0]       addr
);

  always_comb begin
    addr = {base, idx, {OFS_W{1'b0}}};
  end

endmodule

// File: rtl/cwf_burst_seq.sv
module cwf_burst_seq #(
  parameter int ADDR_W   = 32,
  parameter int BEATS    = 4,
  parameter int DW_BYTES = 8,
  localparam int IDX_W   = $clog2(BEATS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  output logic              req_ready,
  output logic              req_err,
  input  logic              mem_ready,
  output logic              beat_valid,
  output logic [IDX_W-1:0]  beat_idx,
  output logic [ADDR_W-1:0] beat_addr,
  output logic              beat_last
);

  import cwf_pkg::*;

  localparam int OFS_W  = $clog2(DW_BYTES);
  localparam int BLK_W  = IDX_W + OFS_W;
  localparam int BASE_W = ADDR_W - BLK_W;

  seq_state_e        state_q;
  seq_state_e        state_d;
  logic [BASE_W-1:0] base_q;
  logic [BASE_W-1:0] base_d;
  logic              base_en;
  logic              err_q;
  logic              err_d;

  logic busy;
  logic take;
  logic bad;
  logic accept;
  logic advance;
  logic ctr_last;

  cwf_align_chk #(
    .ADDR_W (ADDR_W),
    .IDX_W  (IDX_W),
    .OFS_W  (OFS_W)
  ) u_align (
    .addr  (req_addr),
    .write (req_write),
    .bad   (bad)
  );

  always_comb begin
    busy    = (state_q == SEQ_BUSY);
    take    = req_valid && !busy;
    accept  = take && !bad;
    err_d   = take && bad;
    advance = busy && mem_ready;
    base_en = accept;
    base_d  = req_addr[ADDR_W-1:BLK_W];
  end

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      SEQ_IDLE: if (accept)              state_d = SEQ_BUSY;
      SEQ_BUSY: if (advance && ctr_last) state_d = SEQ_IDLE;
      default:                           state_d = SEQ_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= SEQ_IDLE;
      base_q  <= '0;
      err_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      err_q   <= err_d;
      if (base_en) base_q <= base_d;
    end
  end

  cwf_beat_ctr #(
    .BEATS (BEATS)
  ) u_ctr (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (accept),
    .start   (req_addr[BLK_W-1:OFS_W]),
    .advance (advance),
    .idx     (beat_idx),
    .last    (ctr_last)
  );

  cwf_addr_gen #(
    .ADDR_W (ADDR_W),
    .IDX_W  (IDX_W),
    .OFS_W  (OFS_W)
  ) u_addr (
    .base (base_q),
    .idx  (beat_idx),
    .addr (beat_addr)
  );

  always_comb begin
    req_ready  = !busy;
    req_err    = err_q;
    beat_valid = busy;
    beat_last  = busy && ctr_last;
  end

  // R2
  idx_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    beat_valid && mem_ready && !beat_last |=>
      beat_valid && (beat_idx == IDX_W'($past(beat_idx) + IDX_W'(1))));

  // R3
  addr_low_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    beat_valid |-> (beat_addr[OFS_W-1:0] == '0));

  // R5
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    beat_valid && !mem_ready |=>
      beat_valid && $stable(beat_idx) && $stable(beat_addr) && $stable(beat_last));

  // R6
  err_no_beat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_err |-> !beat_valid && !$past(req_err));

  // R8
  busy_not_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    beat_valid |-> !req_ready);

  // R9
  last_then_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    beat_valid && beat_last && mem_ready |=> !beat_valid && req_ready);

endmodule

// File: tb/sim_cwf_burst_seq.sv
module sim_cwf_burst_seq;

  logic        clk;
  logic        rst_n;
  logic        req_valid;
  logic        req_write;
  logic [31:0] req_addr;
  logic        req_ready;
  logic        req_err;
  logic        mem_ready;
  logic        beat_valid;
  logic [1:0]  beat_idx;
  logic [31:0] beat_addr;
  logic        beat_last;

  int  tests = 0;
  int  fails = 0;
  bit  done  = 0;

  cwf_burst_seq u0 (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .req_write  (req_write),
    .req_addr   (req_addr),
    .req_ready  (req_ready),
    .req_err    (req_err),
    .mem_ready  (mem_ready),
    .beat_valid (beat_valid),
    .beat_idx   (beat_idx),
    .beat_addr  (beat_addr),
    .beat_last  (beat_last)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  // Fields: {write, expect_refusal, address}
  localparam int NVEC = 9;
  localparam logic [33:0] VEC [NVEC] = '{
    {1'b0, 1'b0, 32'h0000_1000},
    {1'b0, 1'b0, 32'h0000_1008},
    {1'b0, 1'b0, 32'h8000_0010},
    {1'b0, 1'b0, 32'hFFFF_FFF8},
    {1'b0, 1'b0, 32'hA5A5_A5B0},
    {1'b1, 1'b0, 32'h1234_5660},
    {1'b1, 1'b1, 32'h1234_5668},
    {1'b0, 1'b1, 32'h0000_0004},
    {1'b1, 1'b1, 32'h0000_0001}
  };

  task automatic check(input bit ok, input string tag,
                       input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] exp_addr(input logic [31:0] a, input logic [1:0] i);
    return {a[31:5], i, 3'b000};
  endfunction

  // Offer one request; returns after the request edge, at a falling edge.
  task automatic offer(input logic wr, input logic [31:0] a);
    @(negedge clk);
    req_valid = 1'b1;
    req_write = wr;
    req_addr  = a;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  // Checks four beats with memory always ready, then the return to idle.
  task automatic run_beats(input logic [31:0] a, input logic [1:0] start, input string tag);
    for (int b = 0; b < 4; b++) begin
      logic [1:0] ei;
      ei = start + 2'(b);
      check(beat_valid === 1'b1, tag, 32'(beat_valid), 32'd1);
      check(beat_idx === ei, tag, 32'(beat_idx), 32'(ei));
      // R3
      check(beat_addr === exp_addr(a, ei), "R3", beat_addr, exp_addr(a, ei));
      // R4
      check(beat_last === (b == 3), "R4", 32'(beat_last), 32'(b == 3));
      if (b < 3) @(negedge clk);
    end
    @(negedge clk);
    // R9
    check(req_ready === 1'b1 && beat_valid === 1'b0, "R9",
          {30'd0, req_ready, beat_valid}, 32'd2);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      tests++;
      fails++;
      $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    rst_n     = 1'b0;
    req_valid = 1'b0;
    req_write = 1'b0;
    req_addr  = '0;
    mem_ready = 1'b1;
    repeat (3) @(negedge clk);
    // R1
    check(beat_valid === 1'b0, "R1", 32'(beat_valid), 32'd0);
    check(req_err === 1'b0, "R1", 32'(req_err), 32'd0);
    check(req_ready === 1'b1, "R1", 32'(req_ready), 32'd1);
    rst_n = 1'b1;
    @(negedge clk);
    check(beat_valid === 1'b0 && req_ready === 1'b1, "R1",
          {30'd0, req_ready, beat_valid}, 32'd2);

    // Table walk: R2 reads, R6/R7 refusals, R7 aligned write.
    for (int v = 0; v < NVEC; v++) begin
      logic        wr;
      logic        er;
      logic [31:0] a;
      {wr, er, a} = VEC[v];
      offer(wr, a);
      if (er) begin
        check(req_err === 1'b1, wr ? "R7" : "R6", 32'(req_err), 32'd1);
        check(beat_valid === 1'b0, wr ? "R7" : "R6", 32'(beat_valid), 32'd0);
        @(negedge clk);
        check(req_err === 1'b0 && beat_valid === 1'b0, "R6",
              {30'd0, req_err, beat_valid}, 32'd0);
      end else begin
        check(req_err === 1'b0, "R2", 32'(req_err), 32'd0);
        run_beats(a, wr ? 2'd0 : a[4:3], wr ? "R7" : "R2");
      end
    end

    // Stall on the first beat while a competing request is offered.
    offer(1'b0, 32'h0000_0458);
    mem_ready = 1'b0;
    req_valid = 1'b1;
    req_write = 1'b0;
    req_addr  = 32'h7777_7700;
    for (int s = 0; s < 3; s++) begin
      @(negedge clk);
      // R5
      check(beat_valid === 1'b1 && beat_idx === 2'd3, "R5", 32'(beat_idx), 32'd3);
      check(beat_addr === 32'h0000_0458, "R5", beat_addr, 32'h0000_0458);
      check(beat_last === 1'b0, "R5", 32'(beat_last), 32'd0);
      // R8
      check(req_ready === 1'b0, "R8", 32'(req_ready), 32'd0);
    end
    mem_ready = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    // R8: the competing request has not redirected the sequence.
    check(beat_idx === 2'd0 && beat_addr === 32'h0000_0440, "R8", beat_addr, 32'h0000_0440);
    @(negedge clk);
    check(beat_idx === 2'd1, "R8", 32'(beat_idx), 32'd1);
    @(negedge clk);
    check(beat_idx === 2'd2 && beat_last === 1'b1, "R4", 32'(beat_last), 32'd1);
    @(negedge clk);
    check(beat_valid === 1'b0 && req_ready === 1'b1, "R9",
          {30'd0, req_ready, beat_valid}, 32'd2);

    // Back-to-back: request held high across the end of a burst.
    @(negedge clk);
    req_valid = 1'b1;
    req_write = 1'b0;
    req_addr  = 32'hC000_0010;
    @(negedge clk);
    for (int b = 0; b < 4; b++) @(negedge clk);
    // R9: idle turnaround cycle, request taken on its edge
    check(beat_valid === 1'b0 && req_ready === 1'b1, "R9",
          {30'd0, req_ready, beat_valid}, 32'd2);
    @(negedge clk);
    req_valid = 1'b0;
    check(beat_valid === 1'b1 && beat_idx === 2'd2, "R2", 32'(beat_idx), 32'd2);
    run_beats(32'hC000_0010, 2'd2, "R2");

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule